// File: doc/BRIEF.md
# Cache Miss and Write Buffer Allocator

This block runs the two small entry pools that sit beside a cache controller: a miss pool for outstanding fills and uncached reads, and a write pool for pending stores and evictions. The cache pipeline presents one allocation request per cycle together with a request kind. The block picks the lowest free slot in the pool that matches that kind. It shapes the address and length that get recorded and stamps the request with a running sequence number. It can also raise a memory-side send strobe, tagged with the pool that the request went to.

Each pool that can stall the pipeline owns one bit of a stall mask, at the bit position equal to its pool number: miss pool 0, write pool 1. While any bit is set, the CPU-side ready output is low. A bit is raised by the allocation that fills its pool. It drops only on the cycle the pool goes from full to not full, either by an issue that hands the entry off or by a release of the entry. A requester that was turned away while the block was stalled receives one retry pulse when the last stall bit clears.

Top module: `cache_buf_alloc`

## Requirements
- R1: An allocation of kind 0 (cacheable miss) goes to pool 0. Its recorded address is the input address with the low log2(BLK_BYTES) bits cleared, and its recorded length is BLK_BYTES.
- R2: An allocation of kind 1 (write or writeback) goes to pool 1 and keeps its exact address and byte size.
- R3: An allocation of kind 2 (uncached read) goes to pool 0 and keeps its exact address and size, with no alignment.
- R4: Every accepted allocation carries a sequence number. The first one after reset is 0, and each later one is the previous value plus one. Refused allocations do not advance it.
- R5: Within a pool, the granted index is the lowest-numbered free slot. The grant outputs are valid in the cycle after the request.
- R6: An allocation that leaves a pool full sets stall_mask bit p (p = pool number) one cycle later and drives cpu_ready low.
- R7: An allocation is refused (alloc_ok low, no grant) when its target pool is full or its kind is 3.
- R8: An issue with issue_release set, on an entry of a full pool, frees that entry and clears the pool's stall bit. An issue without release leaves the stall bit set.
- R9: A free of an entry in a full pool clears that pool's stall bit in the next cycle.
- R10: cpu_retry is a one-cycle pulse. It rises in the cycle stall_mask becomes zero, and only if cpu_req_valid was seen while stall_mask was nonzero since the previous retry.
- R11: An accepted allocation with alloc_send set raises send_req together with its grant, with send_cause equal to the pool number. Without alloc_send, send_req stays low.
- R12: After reset, cpu_ready is 1, stall_mask is 0, and grant_valid, send_req and cpu_retry are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_kind | input | 2 | 0 miss, 1 write, 2 uncached read, 3 invalid |
| alloc_addr | input | AW | Request address |
| alloc_size | input | LW | Request size in bytes (kinds 1 and 2) |
| alloc_send | input | 1 | Request a memory-side send on acceptance |
| alloc_ok | output | 1 | Request accepted this cycle |
| grant_valid | output | 1 | Grant record valid |
| grant_pool | output | PW | Pool of the grant |
| grant_idx | output | IW | Slot index granted |
| grant_seq | output | SW | Sequence number |
| grant_addr | output | AW | Recorded address |
| grant_len | output | LW | Recorded length |
| send_req | output | 1 | Memory-side send strobe |
| send_cause | output | PW | Pool that caused the send |
| issue_valid | input | 1 | Mark an entry in service |
| issue_pool | input | PW | Pool of the issued entry |
| issue_idx | input | IW | Slot of the issued entry |
| issue_release | input | 1 | Free the slot on issue |
| free_valid | input | 1 | Release an entry |
| free_pool | input | PW | Pool of the released entry |
| free_idx | input | IW | Slot of the released entry |
| cpu_req_valid | input | 1 | CPU-side request presented |
| cpu_ready | output | 1 | CPU side may accept requests |
| cpu_retry | output | 1 | One-cycle retry pulse |
| stall_mask | output | NPOOL | Per-pool stall bits |

## Verification
The pool assertions take for granted that an issue names a slot that is allocated and not yet in service, and that a free names an allocated slot. They also assume an issue and a free never target the same slot in one cycle, and that no issue or free index lies past the pool depth. The directed tasks keep a model of which slots are occupied and only issue or free slots they were granted, one operation per cycle. The control logic itself guarantees that an allocation is never presented to a full pool, and an assertion watches that the stall bits always equal the pools' full flags.

// File: rtl/cba_pkg.sv
package cba_pkg;
   localparam int NPOOL      = 2;
   localparam int POOL_MISS  = 0;
   localparam int POOL_WRITE = 1;

   typedef enum logic [1:0] {
      KIND_MISS   = 2'd0,
      KIND_WRITE  = 2'd1,
      KIND_UNC_RD = 2'd2,
      KIND_BAD    = 2'd3
   } req_kind_e;
endpackage

// File: rtl/cba_pool.sv
module cba_pool #(
   parameter int DEPTH = 4,
   parameter int IW    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc_en,
   input  logic          issue_en,
   input  logic          issue_rel,
   input  logic [IW-1:0] issue_idx,
   input  logic          free_en,
   input  logic [IW-1:0] free_idx,
   output logic          full,
   output logic [IW-1:0] pick_idx,
   output logic          fill_evt,
   output logic          drain_evt
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("cba_pool: DEPTH must be at least 2");
   end
   if ((1 << IW) < DEPTH) begin : g_bad_iw
      $error("cba_pool: IW too narrow for DEPTH");
   end

   logic [DEPTH-1:0] occ_q, occ_d;
   logic [DEPTH-1:0] svc_q, svc_d;

   // lowest free slot wins
   always_comb begin
      pick_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!occ_q[i]) pick_idx = IW'(i);
      end
   end

   assign full = &occ_q;

   always_comb begin
      occ_d = occ_q;
      svc_d = svc_q;
      if (free_en) begin
         occ_d[free_idx] = 1'b0;
         svc_d[free_idx] = 1'b0;
      end
      if (issue_en) begin
         svc_d[issue_idx] = 1'b1;
         if (issue_rel) begin
            occ_d[issue_idx] = 1'b0;
            svc_d[issue_idx] = 1'b0;
         end
      end
      if (alloc_en) begin
         occ_d[pick_idx] = 1'b1;
         svc_d[pick_idx] = 1'b0;
      end
   end

   assign fill_evt  = alloc_en & (&occ_d);
   assign drain_evt = full & ~(&occ_d);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q <= '0;
         svc_q <= '0;
      end else begin
         occ_q <= occ_d;
         svc_q <= svc_d;
      end
   end

   assert_issue_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      issue_en |-> (occ_q[issue_idx] && !svc_q[issue_idx] && int'(issue_idx) < DEPTH));
   assert_free_occupied_R9: assert property (@(posedge clk) disable iff (!rst_n)
      free_en |-> (occ_q[free_idx] && int'(free_idx) < DEPTH));
   assert_no_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (free_en && issue_en) |-> (free_idx != issue_idx));
   assert_alloc_not_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> !full);
   assert_unfull_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(full) |-> $past(free_en || (issue_en && issue_rel)));
endmodule

// File: rtl/cba_block_ctl.sv
module cba_block_ctl #(
   parameter int NC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NC-1:0] set_vec,
   input  logic [NC-1:0] clr_vec,
   input  logic          cpu_req_valid,
   output logic [NC-1:0] mask,
   output logic          cpu_ready,
   output logic          cpu_retry
);
   logic [NC-1:0] mask_q, mask_d;
   logic          pend_q, pend_d;
   logic          retry_q, retry_d;
   logic          refused_now, last_clear;

   assign mask_d      = (mask_q | set_vec) & ~clr_vec;
   assign refused_now = cpu_req_valid & (|mask_q);
   assign last_clear  = (|mask_q) & ~(|mask_d);

   always_comb begin
      if (last_clear) begin
         retry_d = pend_q | refused_now;
         pend_d  = 1'b0;
      end else begin
         retry_d = 1'b0;
         pend_d  = pend_q | refused_now;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '0;
         pend_q  <= 1'b0;
         retry_q <= 1'b0;
      end else begin
         mask_q  <= mask_d;
         pend_q  <= pend_d;
         retry_q <= retry_d;
      end
   end

   assign mask      = mask_q;
   assign cpu_ready = ~(|mask_q);
   assign cpu_retry = retry_q;

   assert_set_clr_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec & clr_vec) == '0);
   assert_block_after_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> !cpu_ready);
   assert_retry_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_retry |=> !cpu_retry);
   assert_retry_when_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_retry |-> (cpu_ready && $rose(cpu_ready)));
endmodule

// File: rtl/cache_buf_alloc.sv
module cache_buf_alloc
   import cba_pkg::*;
#(
   parameter int AW         = 32,
   parameter int BLK_BYTES  = 64,
   parameter int MISS_DEPTH = 4,
   parameter int WR_DEPTH   = 4,
   parameter int SW         = 8,
   localparam int LW        = $clog2(BLK_BYTES) + 1,
   localparam int MAXD      = (MISS_DEPTH > WR_DEPTH) ? MISS_DEPTH : WR_DEPTH,
   localparam int IW        = $clog2(MAXD),
   localparam int PW        = $clog2(NPOOL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_valid,
   input  logic [1:0]       alloc_kind,
   input  logic [AW-1:0]    alloc_addr,
   input  logic [LW-1:0]    alloc_size,
   input  logic             alloc_send,
   output logic             alloc_ok,
   output logic             grant_valid,
   output logic [PW-1:0]    grant_pool,
   output logic [IW-1:0]    grant_idx,
   output logic [SW-1:0]    grant_seq,
   output logic [AW-1:0]    grant_addr,
   output logic [LW-1:0]    grant_len,
   output logic             send_req,
   output logic [PW-1:0]    send_cause,
   input  logic             issue_valid,
   input  logic [PW-1:0]    issue_pool,
   input  logic [IW-1:0]    issue_idx,
   input  logic             issue_release,
   input  logic             free_valid,
   input  logic [PW-1:0]    free_pool,
   input  logic [IW-1:0]    free_idx,
   input  logic             cpu_req_valid,
   output logic             cpu_ready,
   output logic             cpu_retry,
   output logic [NPOOL-1:0] stall_mask
);
   if (BLK_BYTES < 2 || (BLK_BYTES & (BLK_BYTES - 1)) != 0) begin : g_bad_blk
      $error("cache_buf_alloc: BLK_BYTES must be a power of two");
   end
   if (SW < 1 || AW <= LW) begin : g_bad_width
      $error("cache_buf_alloc: widths out of range");
   end

   localparam logic [AW-1:0] ALIGN_MASK = ~(AW'(BLK_BYTES - 1));

   req_kind_e            kind;
   logic                 kind_ok;
   logic [PW-1:0]        tgt_pool;
   logic [AW-1:0]        fmt_addr;
   logic [LW-1:0]        fmt_len;
   logic [NPOOL-1:0]     pool_full, fill_v, drain_v;
   logic [IW-1:0]        pick [NPOOL];
   logic [SW-1:0]        seq_q;

   assign kind     = req_kind_e'(alloc_kind);
   assign kind_ok  = (kind != KIND_BAD);
   assign tgt_pool = (kind == KIND_WRITE) ? PW'(POOL_WRITE) : PW'(POOL_MISS);
   assign alloc_ok = alloc_valid & kind_ok & ~pool_full[tgt_pool];

   always_comb begin
      if (kind == KIND_MISS) begin
         fmt_addr = alloc_addr & ALIGN_MASK;
         fmt_len  = LW'(BLK_BYTES);
      end else begin
         fmt_addr = alloc_addr;
         fmt_len  = alloc_size;
      end
   end

   for (genvar p = 0; p < NPOOL; p++) begin : g_pool
      localparam int DEP = (p == POOL_MISS) ? MISS_DEPTH : WR_DEPTH;
      cba_pool #(.DEPTH(DEP), .IW(IW)) u_pool (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc_en  (alloc_ok && (int'(tgt_pool) == p)),
         .issue_en  (issue_valid && (int'(issue_pool) == p)),
         .issue_rel (issue_release),
         .issue_idx (issue_idx),
         .free_en   (free_valid && (int'(free_pool) == p)),
         .free_idx  (free_idx),
         .full      (pool_full[p]),
         .pick_idx  (pick[p]),
         .fill_evt  (fill_v[p]),
         .drain_evt (drain_v[p])
      );
   end

   cba_block_ctl #(.NC(NPOOL)) u_blk (
      .clk           (clk),
      .rst_n         (rst_n),
      .set_vec       (fill_v),
      .clr_vec       (drain_v),
      .cpu_req_valid (cpu_req_valid),
      .mask          (stall_mask),
      .cpu_ready     (cpu_ready),
      .cpu_retry     (cpu_retry)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_valid <= 1'b0;
         grant_pool  <= '0;
         grant_idx   <= '0;
         grant_seq   <= '0;
         grant_addr  <= '0;
         grant_len   <= '0;
         send_req    <= 1'b0;
         send_cause  <= '0;
         seq_q       <= '0;
      end else begin
         grant_valid <= alloc_ok;
         send_req    <= alloc_ok & alloc_send;
         if (alloc_ok) begin
            grant_pool <= tgt_pool;
            grant_idx  <= pick[tgt_pool];
            grant_seq  <= seq_q;
            grant_addr <= fmt_addr;
            grant_len  <= fmt_len;
            send_cause <= tgt_pool;
            seq_q      <= seq_q + 1'b1;
         end
      end
   end

   assert_mask_is_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stall_mask == pool_full);
   assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_ok && grant_valid) |=> (grant_seq == $past(grant_seq) + 1'b1));
   assert_send_with_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
      send_req |-> (grant_valid && send_cause == grant_pool));
   assert_grant_follows_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> $past(alloc_ok));
   assert_miss_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && $past(kind == KIND_MISS)) |->
         ((grant_addr & ~ALIGN_MASK) == '0 && grant_len == LW'(BLK_BYTES)));
endmodule

// File: tb/cache_buf_alloc_tb.sv
`timescale 1ns/1ps
module cache_buf_alloc_tb;
   localparam int AW = 32, BLK = 64, SW = 8, LW = 7, IW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic alloc_valid = 0, alloc_send = 0;
   logic [1:0] alloc_kind = 0;
   logic [AW-1:0] alloc_addr = 0;
   logic [LW-1:0] alloc_size = 0;
   logic alloc_ok, grant_valid, send_req, cpu_ready, cpu_retry;
   logic [0:0] grant_pool, send_cause;
   logic [IW-1:0] grant_idx;
   logic [SW-1:0] grant_seq;
   logic [AW-1:0] grant_addr;
   logic [LW-1:0] grant_len;
   logic issue_valid = 0, issue_release = 0, free_valid = 0, cpu_req_valid = 0;
   logic [0:0] issue_pool = 0, free_pool = 0;
   logic [IW-1:0] issue_idx = 0, free_idx = 0;
   logic [1:0] stall_mask;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   cache_buf_alloc u_dut (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_addr(alloc_addr),
      .alloc_size(alloc_size), .alloc_send(alloc_send), .alloc_ok(alloc_ok),
      .grant_valid(grant_valid), .grant_pool(grant_pool), .grant_idx(grant_idx),
      .grant_seq(grant_seq), .grant_addr(grant_addr), .grant_len(grant_len),
      .send_req(send_req), .send_cause(send_cause),
      .issue_valid(issue_valid), .issue_pool(issue_pool), .issue_idx(issue_idx),
      .issue_release(issue_release), .free_valid(free_valid), .free_pool(free_pool),
      .free_idx(free_idx), .cpu_req_valid(cpu_req_valid), .cpu_ready(cpu_ready),
      .cpu_retry(cpu_retry), .stall_mask(stall_mask)
   );

   task automatic chk(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // one allocation; checks acceptance and the registered grant
   task automatic do_alloc(string req, int kind, longint addr, int size, bit send,
                           bit exp_ok, int exp_pool, int exp_idx, int exp_seq,
                           longint exp_addr, int exp_len);
      @(negedge clk);
      alloc_valid = 1; alloc_kind = 2'(kind); alloc_addr = AW'(addr);
      alloc_size = LW'(size); alloc_send = send;
      #1 chk(req, "alloc_ok", alloc_ok, exp_ok);
      @(posedge clk); #1;
      alloc_valid = 0; alloc_send = 0;
      chk(req, "grant_valid", grant_valid, exp_ok);
      chk(req, "send_req", send_req, exp_ok & send);
      if (exp_ok) begin
         chk(req, "grant_pool", grant_pool, exp_pool);
         chk(req, "grant_idx", grant_idx, exp_idx);
         chk(req, "grant_seq", grant_seq, exp_seq);
         chk(req, "grant_addr", grant_addr, exp_addr);
         chk(req, "grant_len", grant_len, exp_len);
         if (send) chk(req, "send_cause", send_cause, exp_pool);
      end
   endtask

   // issue (is_free=0) or free (is_free=1); checks stall state after the edge
   task automatic do_op(string req, bit is_free, int pool, int idx, bit rel,
                        int exp_mask, bit exp_retry);
      @(negedge clk);
      if (is_free) begin
         free_valid = 1; free_pool = 1'(pool); free_idx = IW'(idx);
      end else begin
         issue_valid = 1; issue_pool = 1'(pool); issue_idx = IW'(idx); issue_release = rel;
      end
      @(posedge clk); #1;
      free_valid = 0; issue_valid = 0; issue_release = 0;
      chk(req, "stall_mask", stall_mask, exp_mask);
      chk(req, "cpu_ready", cpu_ready, exp_mask == 0);
      chk(req, "cpu_retry", cpu_retry, exp_retry);
   endtask

   task automatic cpu_knock();
      @(negedge clk);
      cpu_req_valid = 1;
      @(posedge clk); #1;
      cpu_req_valid = 0;
   endtask

   task automatic idle_check(string req, int exp_mask, bit exp_retry);
      @(posedge clk); #1;
      chk(req, "stall_mask", stall_mask, exp_mask);
      chk(req, "cpu_retry", cpu_retry, exp_retry);
   endtask

   task automatic t_reset();
      @(posedge clk); #1;
      chk("R12", "cpu_ready", cpu_ready, 1);
      chk("R12", "stall_mask", stall_mask, 0);
      chk("R12", "grant_valid", grant_valid, 0);
      chk("R12", "send_req", send_req, 0);
      chk("R12", "cpu_retry", cpu_retry, 0);
   endtask

   task automatic t_kinds();
      do_alloc("R7", 3, 64'h100, 4, 1, 0, 0, 0, 0, 0, 0);
      do_alloc("R1", 0, 64'h1234_5678, 9, 1, 1, 0, 0, 0, 64'h1234_5640, BLK);
      do_alloc("R2", 1, 64'hABCD_0013, 4, 0, 1, 1, 0, 1, 64'hABCD_0013, 4);
      do_alloc("R3", 2, 64'h0000_1003, 2, 1, 1, 0, 1, 2, 64'h0000_1003, 2);
   endtask

   task automatic t_fill_miss();
      do_alloc("R5", 0, 64'h2000_007F, 0, 0, 1, 0, 2, 3, 64'h2000_0040, BLK);
      chk("R6", "stall_mask early", stall_mask, 0);
      do_alloc("R6", 0, 64'h3000_0001, 0, 0, 1, 0, 3, 4, 64'h3000_0000, BLK);
      chk("R6", "stall_mask", stall_mask, 1);
      chk("R6", "cpu_ready", cpu_ready, 0);
      do_alloc("R7", 0, 64'h4000_0000, 0, 1, 0, 0, 0, 0, 0, 0);
      cpu_knock();
   endtask

   task automatic t_issue();
      do_op("R8", 0, 0, 1, 0, 1, 0);
      do_op("R10", 0, 0, 2, 1, 0, 1);
      idle_check("R10", 0, 0);
      do_alloc("R5", 0, 64'h5000_0000, 0, 0, 1, 0, 2, 5, 64'h5000_0000, BLK);
      chk("R6", "stall_mask refill", stall_mask, 1);
      do_op("R9", 1, 0, 0, 0, 0, 0);
   endtask

   task automatic t_write_pool();
      do_alloc("R11", 1, 64'h6000_0001, 8, 1, 1, 1, 1, 6, 64'h6000_0001, 8);
      do_alloc("R11", 1, 64'h6000_0002, 1, 1, 1, 1, 2, 7, 64'h6000_0002, 1);
      do_alloc("R6", 1, 64'h6000_0003, 2, 1, 1, 1, 3, 8, 64'h6000_0003, 2);
      chk("R6", "write stall", stall_mask, 2);
      cpu_knock();
      do_op("R10", 1, 1, 2, 0, 0, 1);
   endtask

   task automatic t_both();
      do_alloc("R5", 0, 64'h7000_0010, 0, 0, 1, 0, 0, 9, 64'h7000_0000, BLK);
      do_alloc("R6", 1, 64'h8000_0004, 4, 0, 1, 1, 2, 10, 64'h8000_0004, 4);
      chk("R6", "both stall", stall_mask, 3);
      cpu_knock();
      do_op("R10", 1, 0, 3, 0, 2, 0);
      do_op("R10", 1, 1, 1, 0, 0, 1);
      idle_check("R10", 0, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      t_reset();
      t_kinds();
      t_fill_miss();
      t_issue();
      t_write_pool();
      t_both();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule